// File: doc/BRIEF.md
# Daisy-Chain Serial Shift Front End

This block is the serial receiver that sits in front of a DAC command decoder. It takes a three-wire, SPI mode 0 style link: an active-low select, a serial clock that idles low and a data line. While the select is low, every rising serial-clock edge shifts one bit into a 16-bit shift register. The select may stay low across a pause in the serial clock, so a word can arrive as one 16-bit burst or as two 8-bit bursts. When the select rises and exactly 16 bits were taken in that window, the captured word is handed to the decoder with a one-cycle strobe. Any other bit count is thrown away.

The oldest bit of the shift register also drives a serial output, which supports daisy-chaining and readback. In the default timing the output repeats the input 16 serial clocks later and changes after a rising edge. In the alternative timing the output is re-timed by half a serial clock, so the lag is 16.5 clocks and the output changes after a falling edge. The decoder chooses the timing with a load strobe. While the device is shut down the serial output holds its value, while shifting and word capture carry on.

All three link inputs are oversampled by a fast system clock through two-flop synchronizers and edge detectors, so the block has a single clock domain. The serial clock must therefore stay well below half the system clock rate.

Top module: `sdac_shift_front`

## Requirements
- R1: Serial-clock edges while the select input (active low) is high shift nothing: they change neither the captured word nor the serial output history.
- R2: When the select rises after exactly 16 rising serial-clock edges, `word_valid_o` is high for exactly one system cycle and `word_o` holds the 16 bits with the first received bit at bit 15 and the last at bit 0.
- R3: When the select rises after any count other than 16 (for example 15 or 17), no strobe is given and `word_o` keeps its previous value.
- R4: Two 8-bit bursts separated by an idle serial clock, inside one low period of the select, form one valid 16-bit word.
- R5: The bit counter is cleared whenever the select is high, so a discarded frame does not affect the next frame.
- R6: With `mode_half_i` loaded as 0, `dout_o` after the n-th rising edge (counted since reset over edges taken while selected) is the bit received at rising edge n-16, or 0 when n-16 < 1; it changes only after rising edges.
- R7: With `mode_half_i` loaded as 1, `dout_o` during the high phase after rising edge n shows the bit of edge n-17 and during the following low phase the bit of edge n-16, so it changes after falling edges (16.5 clock lag).
- R8: After reset the 16-clock timing (code 0) is selected; a pulse on `mode_wr_i` loads `mode_half_i` (0 = 16-clock lag, 1 = 16.5-clock lag).
- R9: While `shutdown_i` is high, `dout_o` keeps the value it had when shutdown began; shifting and word capture continue, and after shutdown ends `dout_o` follows the R6 history again.
- R10: A last rising serial-clock edge that is seen in the same sample as the rising select is counted and its bit is part of the captured word.
- R11: After reset `word_valid_o`, `word_o` and `dout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Active-low select; a frame lasts while it is low |
| din_i | input | 1 | Serial data in |
| shutdown_i | input | 1 | High freezes the serial output |
| mode_wr_i | input | 1 | One-cycle pulse loading the output timing |
| mode_half_i | input | 1 | Timing code: 0 = 16-clock lag, 1 = 16.5-clock lag |
| word_valid_o | output | 1 | One-cycle strobe for a complete 16-bit word |
| word_o | output | 16 | Last accepted word, first bit at the MSB |
| dout_o | output | 1 | Serial data out for chaining and readback |

## Verification
The last rising serial-clock edge of a frame and the rising select can land in the same synchronized sample, so the shift and the word capture fall in one system cycle. The bench provokes this by driving the serial clock and the select high at the same instant, then judges that exactly one strobe appears and that the captured word contains the final bit. A second overlap, shutdown with ongoing shifting, is judged by checking that the output stays frozen while the captured word still advances and the output history resumes correctly afterwards.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  localparam int unsigned SDF_WORD_W = 16;
  localparam int unsigned SDF_SYNC_STAGES = 2;

  // Events derived from the synchronized link inputs.
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_rise;     // select goes inactive (frame end)
    logic cs_fall;     // select goes active (frame start)
    logic cs_high;     // select currently inactive
    logic cs_was_low;  // select was active in the previous sample
  } sdf_evt_t;

  function automatic logic is_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic is_fall(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
  parameter int unsigned N = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] out_o
);

  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= in_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign out_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdf_edges.sv
module sdf_edges
  import sdf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s_i,
  input  logic     csn_s_i,
  output sdf_evt_t evt_o
);

  logic sclk_p_q;
  logic csn_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p_q <= 1'b0;
      csn_p_q  <= 1'b1;
    end else begin
      sclk_p_q <= sclk_s_i;
      csn_p_q  <= csn_s_i;
    end
  end

  always_comb begin
    evt_o.sclk_rise  = is_rise(sclk_s_i, sclk_p_q);
    evt_o.sclk_fall  = is_fall(sclk_s_i, sclk_p_q);
    evt_o.cs_rise    = is_rise(csn_s_i, csn_p_q);
    evt_o.cs_fall    = is_fall(csn_s_i, csn_p_q);
    evt_o.cs_high    = csn_s_i;
    evt_o.cs_was_low = ~csn_p_q;
  end

  // A frame end can only follow a frame start.
  AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.cs_rise |-> $past(!csn_s_i)); // R5

endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter
  import sdf_pkg::*;
#(
  parameter int unsigned WORD_W = SDF_WORD_W,
  localparam int unsigned CNT_MAX = WORD_W + 1,
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdf_evt_t          evt_i,
  input  logic              din_s_i,
  output logic              shift_en_o,
  output logic              tail_o,
  output logic              frame_ok_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);

  // Saturating bit count: anything above WORD_W stays above it.
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(CNT_MAX)) ? c : c + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] r, input logic b);
    return {r[WORD_W-2:0], b};
  endfunction

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  // A sample counts when the select was active before this edge, so a
  // select rise seen in the same sample still keeps the last bit.
  assign shift_en_o = evt_i.sclk_rise & evt_i.cs_was_low;
  assign tail_o     = sr_q[WORD_W-1];

  always_comb begin
    sr_d  = shift_en_o ? shift_in(sr_q, din_s_i) : sr_q;
    cnt_d = shift_en_o ? cnt_step(cnt_q) : cnt_q;
  end

  assign frame_ok_o = evt_i.cs_rise & (cnt_d == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      cnt_q   <= evt_i.cs_high ? '0 : cnt_d;
      valid_q <= frame_ok_o;
      if (frame_ok_o) word_q <= sr_d;
    end
  end

  assign word_valid_o = valid_q;
  assign word_o       = word_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o); // R2

  AST_STROBE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(evt_i.cs_rise)); // R2

  AST_DISCARD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.cs_rise && !frame_ok_o) |=> ($stable(word_o) && !word_valid_o)); // R3

  AST_FRAME_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.cs_fall |-> (cnt_q == '0)); // R5

endmodule

// File: rtl/sdf_dout.sv
module sdf_dout
  import sdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en_i,
  input  logic tail_i,
  input  logic sclk_fall_i,
  input  logic mode_wr_i,
  input  logic mode_half_i,
  input  logic shutdown_i,
  output logic dout_o
);

  logic half_q;   // 0: 16-clock lag, 1: 16.5-clock lag
  logic full_q;   // retimed on rising serial-clock edges
  logic half_dq;  // full_q retimed on falling serial-clock edges
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      full_q  <= 1'b0;
      half_dq <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      if (mode_wr_i)   half_q  <= mode_half_i;
      if (shift_en_i)  full_q  <= tail_i;
      if (sclk_fall_i) half_dq <= full_q;
      if (!shutdown_i) out_q   <= half_q ? half_dq : full_q;
    end
  end

  assign dout_o = out_q;

  AST_FROZEN_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> $stable(dout_o)); // R9

  AST_FULL_ONLY_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(full_q) |-> $past(shift_en_i)); // R6

  AST_HALF_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_dq) |-> $past(sclk_fall_i)); // R7

endmodule

// File: rtl/sdac_shift_front.sv
module sdac_shift_front
  import sdf_pkg::*;
#(
  parameter int unsigned WORD_W = SDF_WORD_W,
  parameter int unsigned SYNC_STAGES = SDF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              din_i,
  input  logic              shutdown_i,
  input  logic              mode_wr_i,
  input  logic              mode_half_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              dout_o
);

  // Bit order of the synchronized bundle: {csn, sclk, din}.
  logic [2:0] link_s;
  sdf_evt_t   evt;
  logic       shift_en;
  logic       tail;
  logic       frame_ok;

  sdf_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  ({csn_i, sclk_i, din_i}),
    .out_o (link_s)
  );

  sdf_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s_i (link_s[1]),
    .csn_s_i  (link_s[2]),
    .evt_o    (evt)
  );

  sdf_shifter #(
    .WORD_W (WORD_W)
  ) u_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .din_s_i      (link_s[0]),
    .shift_en_o   (shift_en),
    .tail_o       (tail),
    .frame_ok_o   (frame_ok),
    .word_valid_o (word_valid_o),
    .word_o       (word_o)
  );

  sdf_dout u_dout (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en_i  (shift_en),
    .tail_i      (tail),
    .sclk_fall_i (evt.sclk_fall),
    .mode_wr_i   (mode_wr_i),
    .mode_half_i (mode_half_i),
    .shutdown_i  (shutdown_i),
    .dout_o      (dout_o)
  );

  // Serial-clock edges outside a frame never feed the shift path.
  AST_NO_SHIFT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cs_high && !evt.cs_rise) |-> !shift_en); // R1

  AST_FRAME_OK_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> word_valid_o); // R10

endmodule

// File: tb/sdac_shift_front_bench.sv
module sdac_shift_front_bench;

  localparam int H = 8;  // serial half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        csn = 1'b1;
  logic        din = 1'b0;
  logic        shutdown = 1'b0;
  logic        mode_wr = 1'b0;
  logic        mode_half = 1'b0;
  logic        word_valid;
  logic [15:0] word;
  logic        dout;

  always #4 clk = ~clk;  // 125 MHz

  sdac_shift_front u_sdac_shift_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (sclk),
    .csn_i        (csn),
    .din_i        (din),
    .shutdown_i   (shutdown),
    .mode_wr_i    (mode_wr),
    .mode_half_i  (mode_half),
    .word_valid_o (word_valid),
    .word_o       (word),
    .dout_o       (dout)
  );

  int   total = 0;
  int   fails = 0;
  bit   done = 0;
  int   strobes = 0;
  bit   hist [0:4095];
  int   nrise = 0;
  logic [15:0] exp_sr = '0;
  logic [15:0] last_word = '0;
  bit   half_mode = 0;
  bit   frozen = 0;
  bit   frozen_val = 0;

  always @(negedge clk) if (word_valid) strobes++;

  function automatic bit hbit(input int i);
    return (i < 1) ? 1'b0 : hist[i];
  endfunction

  // Expected serial output in the high phase after rise n (hi=1) or in the low phase.
  function automatic bit exp_dout(input int n, input bit hi);
    if (frozen) return frozen_val;
    if (half_mode && hi) return hbit(n - 17);
    return hbit(n - 16);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input bit m);
    mode_half = m; mode_wr = 1'b1;
    wclk(1);
    mode_wr = 1'b0; half_mode = m;
    wclk(2);
  endtask

  // One frame of nbits, msb first from data; optional pause after split bits;
  // simul raises the select together with the last serial-clock rise.
  task automatic frame(input int nbits, input logic [31:0] data, input int split,
                       input bit simul, input string tag);
    bit ok;
    strobes = 0;
    csn = 1'b0;
    wclk(H);
    for (int i = nbits - 1; i >= 0; i--) begin
      din = data[i];
      wclk(H);
      sclk = 1'b1;
      if (simul && i == 0) csn = 1'b1;
      nrise++;
      hist[nrise] = data[i];
      exp_sr = {exp_sr[14:0], data[i]};
      wclk(H - 1);
      chk({tag, " dout high phase (R6/R7)"}, dout, exp_dout(nrise, 1'b1));
      wclk(1);
      sclk = 1'b0;
      wclk(H - 1);
      chk({tag, " dout low phase (R6/R7)"}, dout, exp_dout(nrise, 1'b0));
      wclk(1);
      if (split > 0 && (nbits - i) == split) wclk(4 * H);
    end
    if (!simul) begin
      wclk(H);
      csn = 1'b1;
    end
    wclk(12);
    ok = (nbits == 16);
    if (ok) last_word = exp_sr;
    chk({tag, " strobe count (R2/R3)"}, strobes, ok ? 1 : 0);
    chk({tag, " captured word (R2/R3)"}, word, last_word);
  endtask

  initial begin
    logic [15:0] r;
    void'($urandom(32'h5A17));
    wclk(3);
    chk("R11 reset valid", word_valid, 0);
    chk("R11 reset word", word, 0);
    chk("R11 reset dout", dout, 0);
    rst_n = 1'b1;
    wclk(4);
    chk("R11 after release dout", dout, 0);

    // R8: default timing is the 16-clock lag; R2/R6 random frames
    for (int k = 0; k < 4; k++) begin
      r = 16'($urandom);
      frame(16, {16'h0, r}, 0, 0, "R2 R6 R8 random");
    end
    frame(16, 32'h0000_A5C3, 0, 0, "R2 directed");

    // R4: two 8-bit bursts within one select window
    r = 16'($urandom);
    frame(16, {16'h0, r}, 8, 0, "R4 split");

    // R3: wrong counts discarded; R5 counter cleared for the next frame
    frame(15, 32'h0000_7FFF, 0, 0, "R3 short");
    frame(17, 32'h0001_5555, 0, 0, "R3 long");
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 0, "R5 after discard");

    // R1: serial-clock activity with the select high is ignored
    for (int k = 0; k < 5; k++) begin
      din = 1'($urandom);
      sclk = 1'b1; wclk(H);
      sclk = 1'b0; wclk(H);
    end
    chk("R1 idle clocks dout", dout, exp_dout(nrise, 1'b0));
    chk("R1 idle clocks word", word, last_word);
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 0, "R1 following frame");

    // R7 with R8: half-cycle output timing
    set_mode(1'b1);
    for (int k = 0; k < 3; k++) begin
      r = 16'($urandom);
      frame(16, {16'h0, r}, 0, 0, "R7 R8 half");
    end
    set_mode(1'b0);
    frame(16, 32'h0000_3C96, 0, 0, "R8 back to full");

    // R9: output frozen during shutdown, capture keeps working
    frozen_val = exp_dout(nrise, 1'b0);
    shutdown = 1'b1;
    frozen = 1;
    wclk(2);
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 0, "R9 shutdown");
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 0, "R9 shutdown second");
    shutdown = 1'b0;
    frozen = 0;
    wclk(4);
    chk("R9 release dout", dout, exp_dout(nrise, 1'b0));
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 0, "R9 after release");

    // R10: last rise coincides with the select rise
    frame(16, 32'h0000_8001, 0, 1, "R10 simultaneous");
    r = 16'($urandom);
    frame(16, {16'h0, r}, 0, 1, "R10 simultaneous random");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule